// File: doc/BRIEF.md
# Converter Noise and Triangle Wave Synthesizer

This block sits in front of a converter channel. It makes a synthetic sample stream there. Software places a base code on `base_val` and chooses a wave source with `mode_sel`. Each pulse on `trig` steps the chosen source once. On that same edge, the block loads the output register with the base plus the new wave value.

The block has two sources. The first is a 12-bit pseudo-random shift register, which gives noise. The second is an up/down counter, which gives a triangle. One amplitude code, `amp_code`, sets the limit for both. For noise it sets how many low bits are kept. For the triangle it sets the turning point. With no source selected, each trigger copies the base to the output. Register decoding and bus access belong to the surrounding logic.

Top module: `dac_wave_synth`

## Requirements
- R1: While `rst_n` is low, `data_out` is 0, the noise register holds 0xAAA, and the triangle counter holds 0 and is set to count up.
- R2: When `mode_sel` is 2'b00 or 2'b11, no source is active, and a trigger loads `data_out` with `base_val`.
- R3: `data_out` and both sources change only on a clock edge where `trig` is high. In any other cycle, a change of `base_val` or `amp_code` leaves `data_out` as it was.
- R4: With `mode_sel` = 2'b01 (noise), each trigger steps the register once: s' = {f, s[11:1]}, where f is the XOR of bits 0, 2, 3 and 5 of s. If s is zero, f is forced to 1. After the step, `data_out` = `base_val` + (s' AND mask).
- R5: For an amplitude code n from 0 to 11, the mask keeps bits 0..n. A code of 12 to 15 acts as 11.
- R6: With `mode_sel` = 2'b10 (triangle), the counter starts at 0 counting up. Each trigger moves it one step. It reverses at the peak and again at 0, so the stream is 1, 2, ..., P, P-1, ..., 0, 1, and so on. `data_out` = `base_val` + counter value after the step.
- R7: The triangle peak P is 2^(n+1)-1 for the effective amplitude code n of R5.
- R8: The sum of base and wave saturates at 0xFFF and never wraps.
- R9: In a cycle where `mode_sel` differs from its value in the previous cycle, both sources return to their R1 start values. A trigger in that cycle is dropped, and `data_out` holds.
- R10: The noise register never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00/11 none, 01 noise, 10 triangle |
| amp_code | input | 4 | Amplitude code (noise width, triangle peak) |
| trig | input | 1 | One-cycle conversion trigger strobe |
| base_val | input | 12 | Base code added to the wave value |
| data_out | output | 12 | Output register feeding the converter |

## Verification
Noise is run from its preset under every amplitude code, including the four codes above 11. Each code uses a different base. This separates the mask widths, and it shows whether the clamp takes effect. The triangle is run through more than two full periods at the small peaks, which exposes off-by-one errors at both turning points. A partial climb at the widest peak and a run with a high base exercise saturation. Two further sequences test the hand-off between sources: a mode switch in the middle of a run, and a mode switch in the same cycle as a trigger. These show whether the generators restart and whether a trigger in the switch cycle is dropped.

// File: rtl/dac_wave_synth.sv
module dac_wave_synth #(
  parameter int            W    = 12,
  parameter logic [W-1:0]  SEED = 12'hAAA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_sel,
  input  logic [3:0]   amp_code,
  input  logic         trig,
  input  logic [W-1:0] base_val,
  output logic [W-1:0] data_out
);
  localparam logic [1:0] M_NOISE = 2'b01;
  localparam logic [1:0] M_TRI   = 2'b10;
  localparam logic [3:0] N_MAX   = 4'(W - 1);

  logic [1:0]   mode_q;
  logic [W-1:0] lfsr, lfsr_nx;
  logic [W-1:0] tri_cnt, tri_nx;
  logic         tri_down, down_nx;
  logic [3:0]   n_eff;
  logic [W-1:0] mask, wave_nx;
  logic [W:0]   sum;
  logic         mode_chg, fb;

  assign mode_chg = mode_sel != mode_q;
  assign n_eff    = (amp_code > N_MAX) ? N_MAX : amp_code;
  assign mask     = {W{1'b1}} >> (N_MAX - n_eff);

  assign fb      = (lfsr == '0) ? 1'b1 : (lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5]);
  assign lfsr_nx = {fb, lfsr[W-1:1]};

  always_comb begin
    tri_nx  = tri_cnt;
    down_nx = tri_down;
    if (!tri_down) begin
      if (tri_cnt >= mask) begin
        down_nx = 1'b1;
        tri_nx  = tri_cnt - 1'b1;
      end else begin
        tri_nx  = tri_cnt + 1'b1;
      end
    end else if (tri_cnt == '0) begin
      down_nx = 1'b0;
      tri_nx  = {{(W-1){1'b0}}, 1'b1};
    end else begin
      tri_nx  = tri_cnt - 1'b1;
    end
  end

  assign wave_nx = (mode_sel == M_NOISE) ? (lfsr_nx & mask) :
                   (mode_sel == M_TRI)   ? tri_nx : '0;
  assign sum     = {1'b0, base_val} + {1'b0, wave_nx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 2'b00;
      lfsr     <= SEED;
      tri_cnt  <= '0;
      tri_down <= 1'b0;
      data_out <= '0;
    end else begin
      mode_q <= mode_sel;
      if (mode_chg) begin
        lfsr     <= SEED;
        tri_cnt  <= '0;
        tri_down <= 1'b0;
      end else if (trig) begin
        if (mode_sel == M_NOISE) lfsr <= lfsr_nx;
        if (mode_sel == M_TRI) begin
          tri_cnt  <= tri_nx;
          tri_down <= down_nx;
        end
        data_out <= sum[W] ? {W{1'b1}} : sum[W-1:0];
      end
    end
  end
endmodule

// File: rtl/dac_wave_synth_chk.sv
module dac_wave_synth_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_sel,
  input logic [1:0]   mode_q,
  input logic         trig,
  input logic [W-1:0] base_val,
  input logic [W-1:0] data_out,
  input logic [W-1:0] lfsr,
  input logic [W-1:0] tri_cnt
);
  assert_hold_no_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(data_out));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_sel == mode_q) |=> data_out >= $past(base_val));

  assert_plain_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_sel == mode_q && (mode_sel == 2'b00 || mode_sel == 2'b11))
      |=> data_out == $past(base_val));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != mode_q) |=> (lfsr == 12'hAAA && tri_cnt == '0 && $stable(data_out)));

  assert_tri_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_sel == 2'b10 && mode_q == 2'b10)
      |=> (tri_cnt == $past(tri_cnt) + 1'b1 || tri_cnt + 1'b1 == $past(tri_cnt)));

  always @(posedge clk)
    if (rst_n) assert_lfsr_live_R10: assert (lfsr != '0);
endmodule

bind dac_wave_synth dac_wave_synth_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_q(mode_q),
  .trig(trig), .base_val(base_val), .data_out(data_out),
  .lfsr(lfsr), .tri_cnt(tri_cnt)
);

// File: tb/dac_wave_synth_tb.sv
`timescale 1ns/1ps
module dac_wave_synth_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [3:0]  amp_code = 4'd0;
  logic        trig = 1'b0;
  logic [11:0] base_val = 12'd0;
  logic [11:0] data_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [11:0] m_lfsr;
  logic [11:0] m_cnt;
  bit          m_down;

  always #2.5 clk = ~clk;

  dac_wave_synth u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .amp_code(amp_code),
    .trig(trig), .base_val(base_val), .data_out(data_out)
  );

  task automatic check(input string req, input logic [11:0] exp);
    n_tests++;
    if (data_out !== exp) begin
      n_fail++;
      $display("FAIL %s: data_out=%03h expected=%03h", req, data_out, exp);
    end
  endtask

  function automatic logic [11:0] peak_of(input logic [3:0] c);
    int n = (c > 11) ? 11 : int'(c);
    return 12'((1 << (n + 1)) - 1);
  endfunction

  function automatic logic [11:0] sat_add(input logic [11:0] a, input logic [11:0] b);
    int s = int'(a) + int'(b);
    return (s > 4095) ? 12'hFFF : 12'(s);
  endfunction

  function automatic logic [11:0] lfsr_step(input logic [11:0] s);
    logic f = (s == 0) ? 1'b1 : (s[0] ^ s[2] ^ s[3] ^ s[5]);
    return {f, s[11:1]};
  endfunction

  task automatic pulse;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk) mode_sel = m;
    @(negedge clk);
    m_lfsr = 12'hAAA; m_cnt = 0; m_down = 0;
  endtask

  task automatic tri_model(input logic [11:0] pk);
    if (!m_down) begin
      if (m_cnt >= pk) begin m_down = 1; m_cnt = m_cnt - 1; end
      else m_cnt = m_cnt + 1;
    end else if (m_cnt == 0) begin m_down = 0; m_cnt = 1; end
    else m_cnt = m_cnt - 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] held;
    base_val = 12'h5A5;
    repeat (3) @(negedge clk);
    check("R1 reset value", 12'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: no wave source, both encodings
    foreach (base_val[i]) begin
      base_val = 12'(1 << i) | 12'h003; pulse(); check("R2 copy mode 00", base_val);
    end
    set_mode(2'b11);
    base_val = 12'hFFF; pulse(); check("R2 copy mode 11", 12'hFFF);
    base_val = 12'h000; pulse(); check("R2 copy mode 11", 12'h000);

    // R3: no trigger, inputs wiggle, output holds
    held = data_out;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) base_val = 12'(k * 517); amp_code = 4'(k);
    end
    check("R3 hold without trigger", held);

    // R4 R5: noise under every amplitude code
    for (int c = 0; c < 16; c++) begin
      set_mode(2'b00);
      set_mode(2'b01);
      amp_code = 4'(c);
      base_val = 12'(c * 37);
      for (int k = 0; k < 20; k++) begin
        pulse();
        m_lfsr = lfsr_step(m_lfsr);
        check(c > 11 ? "R5 noise clamp" : "R4 noise step", sat_add(base_val, m_lfsr & peak_of(4'(c))));
      end
    end

    // R3: noise state not advanced without trigger
    held = data_out;
    repeat (5) @(negedge clk);
    pulse();
    m_lfsr = lfsr_step(m_lfsr);
    check("R3 noise idle no step", sat_add(base_val, m_lfsr & peak_of(amp_code)));

    // R6 R7: triangle, full periods at small peaks
    for (int c = 0; c < 5; c++) begin
      set_mode(2'b00);
      set_mode(2'b10);
      amp_code = 4'(c);
      base_val = 12'(c * 100);
      for (int k = 0; k < 4 * int'(peak_of(4'(c))) + 3; k++) begin
        pulse();
        tri_model(peak_of(4'(c)));
        check("R6 R7 triangle", sat_add(base_val, m_cnt));
      end
    end

    // R7 R8: widest peak from a high base, saturation
    set_mode(2'b00);
    set_mode(2'b10);
    amp_code = 4'd15;
    base_val = 12'hFF0;
    for (int k = 0; k < 40; k++) begin
      pulse();
      tri_model(peak_of(4'd15));
      check("R8 saturate", sat_add(base_val, m_cnt));
    end
    set_mode(2'b01);
    amp_code = 4'd11; base_val = 12'hF00;
    pulse(); m_lfsr = lfsr_step(m_lfsr);
    check("R8 noise saturate", sat_add(base_val, m_lfsr));

    // R9: switch mid-run restarts sources
    amp_code = 4'd3; base_val = 12'h010;
    for (int k = 0; k < 7; k++) begin pulse(); m_lfsr = lfsr_step(m_lfsr); end
    set_mode(2'b10);
    pulse(); tri_model(peak_of(4'd3));
    check("R9 triangle restart", 12'h011);
    pulse(); tri_model(peak_of(4'd3));
    set_mode(2'b01);
    pulse(); m_lfsr = lfsr_step(m_lfsr);
    check("R9 noise restart", sat_add(base_val, m_lfsr & 12'h00F));

    // R9: trigger in the switch cycle is dropped
    held = data_out;
    @(negedge clk) begin mode_sel = 2'b10; trig = 1'b1; end
    @(negedge clk) trig = 1'b0;
    check("R9 switch trigger dropped", held);
    m_cnt = 0; m_down = 0;
    pulse(); tri_model(peak_of(4'd3));
    check("R9 first step after switch", sat_add(base_val, m_cnt));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule